// File: doc/BRIEF.md
# Shadowed Calendar Time Counter

This block is the timekeeping core of a real-time clock. It holds seven calendar counters (seconds, minutes, hours, day of month, day of week, month and a 7-bit year counted from 1968) and moves them forward by one second on each pulse of a once-per-second tick input. Carries ripple through the fields in one step. The carry logic covers the different month lengths and a February that gains a day whenever the year counter is a multiple of four.

Software uses a small 16-bit register bus with byte addresses. Reads always return the running counters as they are at that moment, with no snapshot. Software that reads several fields one after another must allow for a seconds rollover between two reads. Writes to a time field do not change the running time. Each write lands in a shadow copy and marks that field as staged. A write of any value to the commit register starts a fixed-length commit. A busy flag in the status register is high while the commit runs. At the end of the commit, every staged field is copied into the running counters at once. A tick that arrives during the commit is held and applied just after the load.

Top module: `cal_clock_core`

## Requirements
- R1: Each tick adds one second. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0 and carry into the day.
- R2: Day of month counts from 1 to the month's length and then returns to 1, advancing the month (1-based, January = 1). Months 4, 6, 9 and 11 have 30 days. Months 1, 3, 5, 7, 8, 10 and 12 have 31.
- R3: Month 2 has 29 days when the year counter is a multiple of 4, and 28 days otherwise.
- R4: Month 12 rolls over to 1 and increments the 7-bit year counter (year = 1968 + counter). The counter wraps from 127 to 0.
- R5: Day of week runs 0 to 6. It advances on every day rollover and wraps 6 to 0, whatever the date fields hold.
- R6: Field registers sit at byte addresses 0x0A seconds, 0x0C minutes, 0x0E hours, 0x10 day of month, 0x12 day of week, 0x14 month and 0x16 year. A read strobe at a clock edge puts the live value, zero-extended, on the read data one cycle later. Any other address except status reads 0.
- R7: A write to a field register changes only the staged copy. The live value reads back unchanged until a commit.
- R8: A write of any data to byte address 0x3C starts a commit. Bit 6 of the status register (0x00) reads 1 for exactly 4 cycles. Then all staged fields load together and the bit returns to 0. Fields not written since the last commit keep their running values.
- R9: A write to the commit register while a commit is already running is ignored and does not extend the busy window.
- R10: A tick that arrives while a commit is running advances the committed time right after the load, so no second is lost.
- R11: After reset the time reads 00:00:00, day of month 1, day of week 0, month 1, year counter 0, and the busy bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, registered |

## Verification
Each result arrives at a fixed edge. A tick on edge N shows up in the counters right after edge N. A read strobed at an edge returns its data just after that edge, so the bench drives every input on the falling edge and samples on the next falling edge. A commit written at edge P0 makes the busy bit read 1 for strobes at P1 through P4. The new values load at P4, so the bench traces status cycle by cycle and expects the first 0 at P5. When the bench moves on from a commit, it waits six cycles before it ticks or reads a field.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int YEAR_W     = 7;
  localparam int BUSY_BIT   = 6;

  localparam logic [ADDR_W-1:0] ADDR_STATUS     = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_FIELD_BASE = 8'h0A;
  localparam logic [ADDR_W-1:0] ADDR_COMMIT     = 8'h3C;

  // field index order matches the address order of the field registers
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOM  = 3;
  localparam int IDX_DOW  = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  typedef struct packed {
    logic [5:0]        sec;
    logic [5:0]        min;
    logic [4:0]        hour;
    logic [4:0]        dom;
    logic [2:0]        dow;
    logic [3:0]        mon;
    logic [YEAR_W-1:0] year;
  } calTime_t;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] stageWr;
    logic                  loadNow;
    logic                  stepNow;
  } calStrobe_t;

  localparam calTime_t TIME_AT_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                         dom: 5'd1, dow: 3'd0, mon: 4'd1,
                                         year: '0};

  function automatic logic [DATA_W-1:0] getField(calTime_t t, int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    case (idx)
      IDX_SEC:  v[5:0]        = t.sec;
      IDX_MIN:  v[5:0]        = t.min;
      IDX_HOUR: v[4:0]        = t.hour;
      IDX_DOM:  v[4:0]        = t.dom;
      IDX_DOW:  v[2:0]        = t.dow;
      IDX_MON:  v[3:0]        = t.mon;
      default:  v[YEAR_W-1:0] = t.year;
    endcase
    return v;
  endfunction

  function automatic calTime_t putField(calTime_t t, int idx, logic [DATA_W-1:0] v);
    calTime_t r;
    r = t;
    case (idx)
      IDX_SEC:  r.sec  = v[5:0];
      IDX_MIN:  r.min  = v[5:0];
      IDX_HOUR: r.hour = v[4:0];
      IDX_DOM:  r.dom  = v[4:0];
      IDX_DOW:  r.dow  = v[2:0];
      IDX_MON:  r.mon  = v[3:0];
      default:  r.year = v[YEAR_W-1:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len #(
  parameter int YEAR_W = 7
) (
  input  logic [3:0]        month,
  input  logic [YEAR_W-1:0] year,
  output logic [4:0]        days
);
  // whole supported span has a leap year exactly on every counter multiple of 4
  logic leapYear;
  assign leapYear = (year[1:0] == 2'b00);

  always_comb begin
    case (month)
      4'd2:                      days = leapYear ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   days = 5'd30;
      default:                   days = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output calStrobe_t        strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES);

  logic [CNT_W-1:0] commitCnt;
  logic             commitReq;
  logic             inCommit;
  logic             tickHeld;

  assign busy      = (commitCnt != '0);
  assign commitReq = busWr && (busAddr == ADDR_COMMIT) && !busy;
  assign inCommit  = busy || commitReq;

  // one write-enable per field register, two byte addresses apart
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fieldDec
    localparam logic [ADDR_W-1:0] FIELD_ADDR = ADDR_FIELD_BASE + ADDR_W'(2 * i);
    assign strobe.stageWr[i] = busWr && (busAddr == FIELD_ADDR);
  end

  assign strobe.loadNow = (commitCnt == CNT_W'(1));
  assign strobe.stepNow = !inCommit && (secTick || tickHeld);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitCnt <= '0;
    end else if (commitReq) begin
      commitCnt <= CNT_LOAD;
    end else if (busy) begin
      commitCnt <= commitCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickHeld <= 1'b0;
    end else if (inCommit && secTick) begin
      tickHeld <= 1'b1;
    end else if (strobe.stepNow) begin
      tickHeld <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output calTime_t          liveTime
);
  calTime_t              shadowTime, shadowNext;
  calTime_t              loadedTime, steppedTime;
  logic [NUM_FIELDS-1:0] staged;
  logic [4:0]            monthDays;
  logic [DATA_W-1:0]     readValue;

  cal_month_len #(.YEAR_W(YEAR_W)) u_monthLen (
    .month (liveTime.mon),
    .year  (liveTime.year),
    .days  (monthDays)
  );

  // staging of field writes
  always_comb begin
    shadowNext = shadowTime;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (strobe.stageWr[i]) shadowNext = putField(shadowNext, i, busWdata);
    end
  end

  // commit merge: only staged fields replace live ones
  always_comb begin
    loadedTime = liveTime;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (staged[i]) loadedTime = putField(loadedTime, i, getField(shadowTime, i));
    end
  end

  // one-second step with carry chain; >= keeps out-of-range writes from sticking
  always_comb begin
    logic secWrap, minWrap, hourWrap, dayWrap, monWrap;
    steppedTime = liveTime;
    secWrap  = (liveTime.sec >= 6'd59);
    minWrap  = secWrap && (liveTime.min >= 6'd59);
    hourWrap = minWrap && (liveTime.hour >= 5'd23);
    dayWrap  = hourWrap && (liveTime.dom >= monthDays);
    monWrap  = dayWrap && (liveTime.mon >= 4'd12);

    steppedTime.sec = secWrap ? 6'd0 : liveTime.sec + 6'd1;
    if (secWrap)  steppedTime.min  = (liveTime.min >= 6'd59) ? 6'd0 : liveTime.min + 6'd1;
    if (minWrap)  steppedTime.hour = (liveTime.hour >= 5'd23) ? 5'd0 : liveTime.hour + 5'd1;
    if (hourWrap) begin
      steppedTime.dom = dayWrap ? 5'd1 : liveTime.dom + 5'd1;
      steppedTime.dow = (liveTime.dow >= 3'd6) ? 3'd0 : liveTime.dow + 3'd1;
    end
    if (dayWrap)  steppedTime.mon  = monWrap ? 4'd1 : liveTime.mon + 4'd1;
    if (monWrap)  steppedTime.year = liveTime.year + YEAR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveTime <= TIME_AT_RESET;
    end else if (strobe.loadNow) begin
      liveTime <= loadedTime;
    end else if (strobe.stepNow) begin
      liveTime <= steppedTime;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowTime <= TIME_AT_RESET;
      staged     <= '0;
    end else begin
      shadowTime <= shadowNext;
      if (strobe.loadNow) staged <= strobe.stageWr;
      else                staged <= staged | strobe.stageWr;
    end
  end

  // read decode of live fields and status
  always_comb begin
    readValue = '0;
    if (busAddr == ADDR_STATUS) readValue[BUSY_BIT] = busy;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (busAddr == ADDR_FIELD_BASE + ADDR_W'(2 * i)) readValue = getField(liveTime, i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= readValue;
  end
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  calStrobe_t strobe;
  logic       busy;
  calTime_t   liveTime;

  cal_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe),
    .busy    (busy)
  );

  cal_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busy     (busy),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .liveTime (liveTime)
  );
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busy,
  input calStrobe_t        strobe,
  input calTime_t          liveTime
);
  localparam int RUN_W = $clog2(COMMIT_CYCLES + 2) + 1;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + RUN_W'(1);
    else           busyRun <= '0;
  end

  // R8: an idle commit write raises busy on the next cycle
  a_r8_commit_starts: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_COMMIT && !busy) |=> busy);

  // R8 and R9: busy window lasts exactly the commit length
  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RUN_W'(COMMIT_CYCLES)));

  a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(COMMIT_CYCLES));

  // R1: a step below the wrap point adds one second
  a_r1_sec_inc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepNow && liveTime.sec < 6'd59) |=> (liveTime.sec == $past(liveTime.sec) + 6'd1));

  // R7: without load or step the live time holds
  a_r7_live_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stepNow && !strobe.loadNow) |=> $stable(liveTime));

  // R10: tick on the load cycle is applied on the next cycle
  a_r10_tick_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadNow && secTick) |=> strobe.stepNow);

  // R2: a step never leaves day of month at zero
  a_r2_dom_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepNow |=> (liveTime.dom != 5'd0));
endmodule

bind cal_clock_core cal_clock_checker #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .secTick  (secTick),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busy     (busy),
  .strobe   (strobe),
  .liveTime (liveTime)
);

// File: tb/cal_clock_core_bench.sv
module cal_clock_core_bench;
  localparam int NF = 7;
  localparam logic [7:0] A_STATUS = 8'h00;
  localparam logic [7:0] A_BASE   = 8'h0A;
  localparam logic [7:0] A_COMMIT = 8'h3C;

  typedef struct packed {
    logic [7:0]         reqId;
    logic [7:0]         ticks;
    logic [0:NF-1][7:0] setVal;
    logic [0:NF-1][7:0] expVal;
  } vec_t;

  function automatic vec_t mk(int r, int t,
      int s0, int s1, int s2, int s3, int s4, int s5, int s6,
      int e0, int e1, int e2, int e3, int e4, int e5, int e6);
    vec_t v;
    v.reqId  = 8'(r);
    v.ticks  = 8'(t);
    v.setVal = {8'(s0), 8'(s1), 8'(s2), 8'(s3), 8'(s4), 8'(s5), 8'(s6)};
    v.expVal = {8'(e0), 8'(e1), 8'(e2), 8'(e3), 8'(e4), 8'(e5), 8'(e6)};
    return v;
  endfunction

  // field order: sec, min, hour, day of month, day of week, month, year counter
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    mk(1, 1, 59,59,23,31,6,12,0,    0,0,0,1,0,1,1),    // R1 full carry, also R4 R5
    mk(3, 1, 59,59,23,28,2,2,1,     0,0,0,1,3,3,1),    // R3 common year
    mk(3, 1, 59,59,23,28,2,2,4,     0,0,0,29,3,2,4),   // R3 leap day reached
    mk(3, 1, 59,59,23,29,3,2,4,     0,0,0,1,4,3,4),    // R3 leap day ends
    mk(2, 1, 59,59,23,30,1,4,5,     0,0,0,1,2,5,5),    // R2 April
    mk(2, 1, 59,59,23,31,5,1,5,     0,0,0,1,6,2,5),    // R2 January
    mk(4, 1, 59,59,23,31,0,12,127,  0,0,0,1,1,1,0),    // R4 year wrap
    mk(1, 2, 58,10,5,15,3,7,20,     0,11,5,15,3,7,20), // R1 minute carry
    mk(1, 50, 10,59,3,9,4,8,30,     0,0,4,9,4,8,30),   // R1 hour carry
    mk(2, 1, 59,59,23,30,2,6,9,     0,0,0,1,3,7,9),    // R2 June
    mk(2, 1, 59,59,23,30,4,11,9,    0,0,0,1,5,12,9),   // R2 November
    mk(6, 0, 56,34,12,17,2,9,50,    56,34,12,17,2,9,50), // R6 map readback
    mk(2, 1, 59,59,23,30,1,9,3,     0,0,0,1,2,10,3),   // R2 September
    mk(5, 1, 59,59,23,10,6,3,2,     0,0,0,11,0,3,2),   // R5 weekday wrap
    mk(2, 1, 59,59,23,30,0,7,2,     0,0,0,31,1,7,2)    // R2 July has 31
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cal_clock_core u_cal_clock_core (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic string reqName(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic fieldCheck(string req, int idx, int exp);
    logic [15:0] d;
    busRead(A_BASE + 8'(2 * idx), d);
    check(req, $sformatf("field %0d", idx), int'(d), exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    fieldCheck("R11", 0, 0); fieldCheck("R11", 1, 0); fieldCheck("R11", 2, 0);
    fieldCheck("R11", 3, 1); fieldCheck("R11", 4, 0); fieldCheck("R11", 5, 1);
    fieldCheck("R11", 6, 0);
    busRead(A_STATUS, d);
    check("R11", "status", int'(d), 0);

    // R7: staged write leaves live seconds alone
    busWrite(A_BASE, 16'd30);
    fieldCheck("R7", 0, 0);

    // R8: busy trace after commit, then load of staged field only
    @(negedge clk);
    busAddr = A_COMMIT; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = A_STATUS; busRd = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R8", $sformatf("busy sample %0d", k), int'(busRdata[6]), (k <= 4) ? 1 : 0);
    end
    busRd = 1'b0;
    fieldCheck("R8", 0, 30);
    fieldCheck("R8", 1, 0);

    // R9: second commit write while busy is ignored
    @(negedge clk);
    busAddr = A_COMMIT; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = A_STATUS; busRd = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R9", $sformatf("busy sample %0d", k), int'(busRdata[6]), (k <= 3) ? 1 : 0);
    end
    busRd = 1'b0;
    settle();

    // R10: tick during commit not lost
    busWrite(A_BASE, 16'd5);
    fieldCheck("R7", 0, 30);
    @(negedge clk);
    busAddr = A_COMMIT; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    settle();
    fieldCheck("R10", 0, 6);

    // R6: unmapped and odd addresses read zero
    busRead(8'h18, d);
    check("R6", "unmapped 0x18", int'(d), 0);
    busRead(8'h0B, d);
    check("R6", "odd 0x0B", int'(d), 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < NF; f++) busWrite(A_BASE + 8'(2 * f), 16'(VECS[v].setVal[f]));
      busWrite(A_COMMIT, 16'hA5A5);
      settle();
      for (int t = 0; t < int'(VECS[v].ticks); t++) tick();
      for (int f = 0; f < NF; f++) begin
        busRead(A_BASE + 8'(2 * f), d);
        check(reqName(int'(VECS[v].reqId)), $sformatf("vector %0d field %0d", v, f),
              int'(d), int'(VECS[v].expVal[f]));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule